// File: doc/BRIEF.md
# SPI Slave Select Framing Unit

This block is the receive-side framing logic of a serial peripheral interface running as a slave. An external master drives the select line, the serial clock and the data line. The unit brings all three into the system clock domain. It decides when a transfer opens and when it closes, shifts in the data bits, and raises a sticky completion interrupt.

Configuration inputs set four things: the active level of the select line, edge or level framing, the word length (1 to 32 bits), and whether a transfer carries one word or two.

- **Edge framing:** a transfer runs from the select's move to active until its move back to inactive.
- **Level framing:** a transfer also ends on its own once the programmed number of bits has arrived. If the select drops early, the transfer is cut short, and a completion flag tells a full transfer from a short one.

Top module: `spi_sel_framer`

## Requirements
- R1: `cfg_sel_hi` sets the select polarity: 1 means a high `sel_in` is active, 0 means a low `sel_in` is active. Holding the inactive level never starts a transfer.
- R2: A move of the select from inactive to active starts a transfer.
  - At that start, `busy` rises, `rx_data` clears to zero and `done_full` clears.
  - While `busy` is high, each rising edge of `sck_in` samples `mosi_in`.
  - The sampled bit enters `rx_data` bit 0 and the older bits move one place toward the MSB, so the first bit received ends up as the most significant received bit.
- R3: With `cfg_level`=0 (edge framing), a transfer ends only when the select returns to inactive. Until then `irq` stays clear and `busy` stays high, whatever the bit count.
- R4: With `cfg_level`=1, returning the select to inactive ends the transfer at once, whatever the bit count. It sets `irq`, and `done_full` reads 1 only if the full programmed count had been received.
- R5: With `cfg_level`=1, the transfer ends by itself when the received bit count reaches the target: `busy` falls, `irq` sets and `done_full` sets. A later select release has no further effect.
- R6: The target bit count is the word length times the word count.
  - The word length is `cfg_bitlen`, where the encoding 0 means 32.
  - The word count is 2 when `cfg_two_words`=1, otherwise 1.
- R7: Clock edges that arrive after the target count has been received are ignored, and `rx_data` keeps the first target bits. With `cfg_level`=0, `done_full` is 1 at the end of such a transfer.
- R8: `irq` is sticky. It stays set until a one-cycle pulse on `irq_clr`, and a set and a clear in the same cycle leave it set.
- R9: `done_full` is low whenever `busy` is high. After reset, `busy`, `irq`, `done_full` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 1 | Slave select from the external master |
| sck_in | input | 1 | Serial clock from the external master |
| mosi_in | input | 1 | Serial data from the external master |
| cfg_sel_hi | input | 1 | 1: select active high, 0: active low |
| cfg_level | input | 1 | 1: level framing, 0: edge framing |
| cfg_bitlen | input | $clog2(MAXLEN) | Bits per word, 0 encodes MAXLEN |
| cfg_two_words | input | 1 | 1: two words per transfer |
| irq_clr | input | 1 | Write-one pulse clearing irq |
| rx_data | output | 2*MAXLEN | Received bits, last bit at bit 0 |
| irq | output | 1 | Sticky completion interrupt |
| done_full | output | 1 | Last transfer received its full count |
| busy | output | 1 | Transfer in progress |

## Verification
A bit counter that is off by one shows up in two ways at the ports.

- **In level framing** the transfer closes one clock early or late. Either `busy` is still high after the last bit, or `rx_data` is shifted by a place, visible a few system cycles after the final clock edge.
- **In edge framing** extra bits overwrite the stored ones, so `rx_data` differs from the first target bits as soon as the extra edge has passed the synchronizer.

A wrong framing state either leaves `busy` stuck, or raises `irq` before the select is released. Both are visible within three system cycles of the select change.

// File: rtl/spi_sel_framer.sv
module spi_sel_framer #(
  parameter int MAXLEN = 32,
  parameter int SYNC   = 2,
  localparam int LW    = $clog2(MAXLEN),
  localparam int TOT   = 2 * MAXLEN,
  localparam int CW    = $clog2(TOT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_in,
  input  logic           sck_in,
  input  logic           mosi_in,
  input  logic           cfg_sel_hi,
  input  logic           cfg_level,
  input  logic [LW-1:0]  cfg_bitlen,
  input  logic           cfg_two_words,
  input  logic           irq_clr,
  output logic [TOT-1:0] rx_data,
  output logic           irq,
  output logic           done_full,
  output logic           busy
);

  logic [SYNC-1:0] sel_sh, sck_sh, dat_sh;
  logic            act_q, sck_q;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh <= '0;
      sck_sh <= '0;
      dat_sh <= '0;
      act_q  <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      sel_sh <= {sel_sh[SYNC-2:0], sel_in};
      sck_sh <= {sck_sh[SYNC-2:0], sck_in};
      dat_sh <= {dat_sh[SYNC-2:0], mosi_in};
      act_q  <= cfg_sel_hi ? sel_sh[SYNC-1] : ~sel_sh[SYNC-1];
      sck_q  <= sck_sh[SYNC-1];
    end
  end

  wire act      = cfg_sel_hi ? sel_sh[SYNC-1] : ~sel_sh[SYNC-1];
  wire start    = act & ~act_q;
  wire stop     = ~act & act_q;
  wire sck_rise = sck_sh[SYNC-1] & ~sck_q;
  wire mosi_s   = dat_sh[SYNC-1];

  wire [CW-1:0] blen   = (cfg_bitlen == '0) ? CW'(MAXLEN) : CW'(cfg_bitlen);
  wire [CW-1:0] target = cfg_two_words ? (blen << 1) : blen;
  wire          full   = (cnt == target);
  wire          take   = busy & sck_rise & ~full & ~stop;
  wire          last   = take & ((cnt + CW'(1)) == target);
  wire          auto_end = cfg_level & last;
  wire          irq_set  = busy & (stop | auto_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rx_data   <= '0;
      done_full <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= '0;
      rx_data   <= '0;
      done_full <= 1'b0;
    end else if (busy) begin
      if (take) begin
        rx_data <= {rx_data[TOT-2:0], mosi_s};
        cnt     <= cnt + CW'(1);
      end
      if (stop) begin
        busy      <= 1'b0;
        done_full <= full;
      end else if (auto_end) begin
        busy      <= 1'b0;
        done_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (irq_set)  irq <= 1'b1;
    else if (irq_clr)  irq <= 1'b0;
  end

endmodule

module spi_sel_framer_chk #(
  parameter int MAXLEN = 32,
  localparam int CW    = $clog2(2 * MAXLEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          irq,
  input logic          irq_clr,
  input logic          done_full,
  input logic          cfg_level,
  input logic          act_q,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] target
);

  a_r4_end_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r8_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !busy) |=> !irq);

  a_r9_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_full |-> !busy);

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= target));

  a_r5_level_no_full_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && busy) |-> (cnt != target));

  a_r3_edge_irq_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level && $rose(irq)) |-> !act_q);

endmodule

bind spi_sel_framer spi_sel_framer_chk #(.MAXLEN(MAXLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .irq_clr(irq_clr),
  .done_full(done_full), .cfg_level(cfg_level), .act_q(act_q),
  .cnt(cnt), .target(target)
);

// File: tb/sim_spi_sel_framer.sv
module sim_spi_sel_framer;
  localparam int MAXLEN = 32;
  localparam int LW = $clog2(MAXLEN);
  localparam int TOT = 2 * MAXLEN;

  logic clk = 0, rst_n = 0;
  logic sel_in = 1, sck_in = 0, mosi_in = 0;
  logic cfg_sel_hi = 0, cfg_level = 0, cfg_two_words = 0, irq_clr = 0;
  logic [LW-1:0] cfg_bitlen = '0;
  logic [TOT-1:0] rx_data;
  logic irq, done_full, busy;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_sel_framer #(.MAXLEN(MAXLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sck_in(sck_in),
    .mosi_in(mosi_in), .cfg_sel_hi(cfg_sel_hi), .cfg_level(cfg_level),
    .cfg_bitlen(cfg_bitlen), .cfg_two_words(cfg_two_words),
    .irq_clr(irq_clr), .rx_data(rx_data), .irq(irq),
    .done_full(done_full), .busy(busy));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_sel(input bit active);
    sel_in = cfg_sel_hi ? active : ~active;
  endtask

  function automatic bit pbit(input logic [63:0] pat, input int k);
    return pat[k % 64];
  endfunction

  task automatic send_bit(input bit b);
    mosi_in = b; tick(3);
    sck_in = 1;  tick(4);
    sck_in = 0;  tick(3);
  endtask

  task automatic run(input bit pol, input bit lvl, input int bl, input bit two,
                     input int nsend, input logic [63:0] pat);
    int tgt, eff;
    logic [TOT-1:0] exp;
    cfg_sel_hi = pol; cfg_level = lvl; cfg_bitlen = LW'(bl); cfg_two_words = two;
    set_sel(0);
    tick(10);
    irq_clr = 1; tick(1); irq_clr = 0; tick(2);
    chk("R8 irq cleared by pulse", TOT'(irq), '0);
    chk("R1 idle level no busy", TOT'(busy), '0);
    tgt = ((bl == 0) ? MAXLEN : bl) * (two ? 2 : 1);
    eff = (nsend < tgt) ? nsend : tgt;
    exp = '0;
    for (int k = 0; k < eff; k++) exp = {exp[TOT-2:0], pbit(pat, k)};
    set_sel(1); tick(5);
    chk("R2 busy after active edge", TOT'(busy), 1);
    chk("R9 done cleared at start", TOT'(done_full), '0);
    for (int k = 0; k < nsend; k++) send_bit(pbit(pat, k));
    tick(5);
    if (lvl && nsend >= tgt) begin
      chk("R5 level auto end irq", TOT'(irq), 1);
      chk("R5 level auto end busy", TOT'(busy), '0);
      chk("R5 level auto end done", TOT'(done_full), 1);
      chk("R6 rx data full count", rx_data, exp);
      set_sel(0); tick(5);
      chk("R5 release after end keeps done", TOT'(done_full), 1);
    end else if (lvl) begin
      chk("R4 level no irq before release", TOT'(irq), '0);
      set_sel(0); tick(5);
      chk("R4 abort irq", TOT'(irq), 1);
      chk("R4 abort busy", TOT'(busy), '0);
      chk("R4 abort done", TOT'(done_full), '0);
      chk("R4 abort partial data", rx_data, exp);
    end else begin
      tick(30);
      chk("R3 edge no irq while active", TOT'(irq), '0);
      chk("R3 edge still busy", TOT'(busy), 1);
      chk("R7 rx data first bits kept", rx_data, exp);
      set_sel(0); tick(5);
      chk("R3 edge irq on release", TOT'(irq), 1);
      chk("R3 edge busy clears", TOT'(busy), '0);
      chk("R7 edge done flag", TOT'(done_full), TOT'(nsend >= tgt));
      chk("R6 rx data after release", rx_data, exp);
    end
    tick(20);
    chk("R8 irq sticky", TOT'(irq), 1);
  endtask

  initial begin
    int bls[7] = '{1, 2, 5, 8, 16, 31, 0};
    int seed = 1;
    logic [63:0] pat;
    tick(3);
    chk("R9 reset busy", TOT'(busy), '0);
    chk("R9 reset irq", TOT'(irq), '0);
    chk("R9 reset done", TOT'(done_full), '0);
    chk("R9 reset data", rx_data, '0);
    rst_n = 1;
    tick(4);
    chk("R1 inactive high no start", TOT'(busy), '0);
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 7; b++)
          for (int w = 0; w < 2; w++) begin
            int tgt = ((bls[b] == 0) ? MAXLEN : bls[b]) * (w + 1);
            seed++;
            pat = {32'(seed) * 32'h9E3779B1, ~32'(seed) * 32'h85EBCA6B};
            run(p[0], l[0], bls[b], w[0], tgt, pat);
            if (l == 1) run(p[0], 1'b1, bls[b], w[0], tgt / 2, ~pat);
            else if (p == 0) run(1'b0, 1'b0, bls[b], w[0], tgt + 2, ~pat);
          end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule